// File: doc/BRIEF.md
# Frequency Offset Tracking Loop

This block follows the carrier offset of a frequency-shift-keyed receiver. On each cycle where a sample is marked valid, it takes the signed instantaneous frequency error from an upstream discriminator. It moves an internal estimate part of the way towards that value. The step size is a right shift selected by configuration. One shift applies while the receiver is still looking for the sync word. A second, usually slower shift applies once the sync word has been found. The integer part of the estimate is presented as a status word, which software can copy into a synthesizer trim field to retune the radio.

The estimate is bounded to a selectable fraction of the channel filter bandwidth. The bandwidth is supplied as an unsigned number in the same units as the error input. The loop can be told to stay frozen until carrier sense has been seen, so that it does not wander while tracking noise. When the receiver is set for on-off keying, the estimate is pinned at zero. A per-packet restart clears the estimate and returns the loop to the acquisition gain.

Top module: `fo_track_loop`

## Requirements
- R1: A synchronous `rst` or a `restart` pulse drives `offset_est` to zero on the next edge. It also clears the sync phase, so the acquisition gain applies, and it clears the remembered carrier sense.
- R2: The estimate changes only on edges where `sample_valid` is high. Otherwise it holds its value, apart from the forced zeroing of R1, R6 and R7.
- R3: The internal estimate has 4 fractional bits. An update computes est += (err·16 − est) >>> (2 + gain), using arithmetic shifts. `offset_est` is the integer part, rounded toward minus infinity.
- R4: `gain_acq` (0..3 meaning shifts 2..5) governs updates until a `sync_found` pulse has been seen. From the edge after that pulse onward, `gain_trk` governs. A sample in the same cycle as the pulse still uses `gain_acq`.
- R5: `limit_sel` = 1, 2 or 3 bounds the estimate after each update to ±(`chan_bw` >> 3), ±(`chan_bw` >> 2) or ±(`chan_bw` >> 1) respectively, by saturation.
- R6: `limit_sel` = 0 disables compensation. The estimate is held at zero and valid samples have no effect.
- R7: While `ook_mode` is high, the estimate is held at zero and valid samples have no effect.
- R8: With `cs_gate_en` high, no update happens until `carrier_sense` has been high in the current cycle or in an earlier cycle since the last reset or restart. After that, updates proceed even if carrier sense drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| restart | input | 1 | Per-packet clear of estimate, phase and carrier-sense memory |
| sample_valid | input | 1 | Qualifies `sample_err` |
| sample_err | input | W | Signed instantaneous frequency error |
| sync_found | input | 1 | Sync-word detected strobe |
| carrier_sense | input | 1 | Carrier sense level |
| ook_mode | input | 1 | High when the modulation is on-off keying |
| cs_gate_en | input | 1 | Freeze the loop until carrier sense is seen |
| limit_sel | input | 2 | Tracking range: 0 off, 1 BW/8, 2 BW/4, 3 BW/2 |
| gain_acq | input | 2 | Shift select before sync (shift = 2 + value) |
| gain_trk | input | 2 | Shift select after sync (shift = 2 + value) |
| chan_bw | input | W | Unsigned channel bandwidth in error units |
| offset_est | output | W | Signed integer part of the offset estimate |

## Verification
Each valid sample shows up in `offset_est` after exactly one rising edge. The bench drives inputs just after a falling edge and reads the output at the next falling edge, half a period after the register has loaded. A `sync_found` pulse changes the gain only for samples after that cycle. The bench therefore sends one sample in the strobe cycle, checks that it used the acquisition shift, and checks that the following sample used the tracking shift. Carrier sense is applied without a sample, then removed, and the sample in the next cycle must still update. This shows that the gate is remembered and is not a level enable.

// File: rtl/fo_track_loop.sv
module fo_track_loop #(
  parameter int W = 16,
  parameter int F = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                restart,
  input  logic                sample_valid,
  input  logic signed [W-1:0] sample_err,
  input  logic                sync_found,
  input  logic                carrier_sense,
  input  logic                ook_mode,
  input  logic                cs_gate_en,
  input  logic [1:0]          limit_sel,
  input  logic [1:0]          gain_acq,
  input  logic [1:0]          gain_trk,
  input  logic [W-1:0]        chan_bw,
  output logic signed [W-1:0] offset_est
);
  localparam int AW = W + F + 2;

  logic signed [AW-1:0] acc, in_ext, diff, step, sum, lim_pos, lim_neg;
  logic [W-1:0] lim;
  logic [2:0]   shamt;
  logic         tracking, cs_seen, enabled, may_update;

  assign enabled    = !ook_mode && (limit_sel != 2'd0);
  assign may_update = sample_valid && (!cs_gate_en || carrier_sense || cs_seen);
  assign shamt      = 3'd2 + {1'b0, (tracking ? gain_trk : gain_acq)};
  assign lim        = chan_bw >> (3'd4 - {1'b0, limit_sel});

  assign in_ext  = {{2{sample_err[W-1]}}, sample_err, {F{1'b0}}};
  assign diff    = in_ext - acc;
  assign step    = diff >>> shamt;
  assign sum     = acc + step;
  assign lim_pos = $signed({2'b00, lim, {F{1'b0}}});
  assign lim_neg = -lim_pos;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      acc      <= '0;
      tracking <= 1'b0;
      cs_seen  <= 1'b0;
    end else begin
      if (sync_found)    tracking <= 1'b1;
      if (carrier_sense) cs_seen  <= 1'b1;
      if (!enabled)
        acc <= '0;
      else if (may_update) begin
        if (sum > lim_pos)      acc <= lim_pos;
        else if (sum < lim_neg) acc <= lim_neg;
        else                    acc <= sum;
      end
    end
  end

  assign offset_est = acc[F+W-1:F];
endmodule

module fo_track_loop_chk #(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                restart,
  input logic                sample_valid,
  input logic                carrier_sense,
  input logic                ook_mode,
  input logic                cs_gate_en,
  input logic [1:0]          limit_sel,
  input logic [W-1:0]        chan_bw,
  input logic signed [W-1:0] offset_est
);
  logic seen;
  logic signed [W:0] bound;

  always_ff @(posedge clk) begin
    if (rst || restart) seen <= 1'b0;
    else if (carrier_sense) seen <= 1'b1;
  end

  always_comb begin
    case (limit_sel)
      2'd1:    bound = $signed({1'b0, chan_bw / 8});
      2'd2:    bound = $signed({1'b0, chan_bw / 4});
      2'd3:    bound = $signed({1'b0, chan_bw / 2});
      default: bound = '0;
    endcase
  end

  a_r1_restart_clears: assert property (@(posedge clk) disable iff (rst)
    restart |=> offset_est == '0);

  a_r2_hold_without_valid: assert property (@(posedge clk) disable iff (rst)
    (!sample_valid && !restart && !ook_mode && limit_sel != 2'd0) |=> $stable(offset_est));

  a_r5_within_limit: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && !restart && !ook_mode && limit_sel != 2'd0 &&
     (!cs_gate_en || carrier_sense || seen))
    |=> ($signed({offset_est[W-1], offset_est}) <= $past(bound) &&
         $signed({offset_est[W-1], offset_est}) >= -$past(bound)));

  a_r6_off_is_zero: assert property (@(posedge clk) disable iff (rst)
    (limit_sel == 2'd0) |=> offset_est == '0);

  a_r7_ook_zero: assert property (@(posedge clk) disable iff (rst)
    ook_mode |=> offset_est == '0);

  a_r8_gate_freezes: assert property (@(posedge clk) disable iff (rst)
    (cs_gate_en && !carrier_sense && !seen && !restart && !ook_mode && limit_sel != 2'd0)
    |=> $stable(offset_est));
endmodule

bind fo_track_loop fo_track_loop_chk #(.W(W)) chk (
  .clk(clk), .rst(rst), .restart(restart), .sample_valid(sample_valid),
  .carrier_sense(carrier_sense), .ook_mode(ook_mode), .cs_gate_en(cs_gate_en),
  .limit_sel(limit_sel), .chan_bw(chan_bw), .offset_est(offset_est)
);

// File: tb/fo_track_loop_test.sv
module fo_track_loop_test;
  localparam int PERIOD = 10;
  localparam int NV = 5;
  localparam int VIN [NV] = '{64, 64, 64, 64, -64};
  localparam int VEX [NV] = '{16, 28, 37, 43, 16};

  logic clk = 1'b0;
  logic rst, restart, sample_valid, sync_found, carrier_sense, ook_mode, cs_gate_en;
  logic signed [15:0] sample_err;
  logic [1:0] limit_sel, gain_acq, gain_trk;
  logic [15:0] chan_bw;
  logic signed [15:0] offset_est;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  fo_track_loop uut (
    .clk(clk), .rst(rst), .restart(restart), .sample_valid(sample_valid),
    .sample_err(sample_err), .sync_found(sync_found), .carrier_sense(carrier_sense),
    .ook_mode(ook_mode), .cs_gate_en(cs_gate_en), .limit_sel(limit_sel),
    .gain_acq(gain_acq), .gain_trk(gain_trk), .chan_bw(chan_bw), .offset_est(offset_est)
  );

  task automatic check(input string req, input int expv);
    tests++;
    if (int'(offset_est) != expv) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, offset_est, expv);
    end
  endtask

  task automatic cyc(input logic v, input int s, input logic sy, input logic cs);
    sample_valid = v; sample_err = 16'(s); sync_found = sy; carrier_sense = cs;
    @(negedge clk);
    sample_valid = 1'b0; sync_found = 1'b0; carrier_sense = 1'b0;
  endtask

  task automatic do_restart();
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
  endtask

  initial begin
    #(PERIOD*20000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; restart = 1'b0; sample_valid = 1'b0; sample_err = '0; sync_found = 1'b0;
    carrier_sense = 1'b0; ook_mode = 1'b0; cs_gate_en = 1'b0; limit_sel = 2'd3;
    gain_acq = 2'd0; gain_trk = 2'd3; chan_bw = 16'd4000;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    check("R1 reset", 0);

    for (int i = 0; i < NV; i++) begin
      cyc(1'b1, VIN[i], 1'b0, 1'b0);
      check("R3 table", VEX[i]);
    end

    cyc(1'b0, 500, 1'b0, 1'b0);
    check("R2 no valid", 16);

    do_restart();
    check("R1 restart", 0);

    cyc(1'b0, 0, 1'b1, 1'b0);
    cyc(1'b1, 64, 1'b0, 1'b0);
    check("R4 post-sync gain", 2);

    do_restart();
    cyc(1'b1, 64, 1'b1, 1'b0);
    check("R4 strobe cycle uses acq gain", 16);
    cyc(1'b1, 64, 1'b0, 1'b0);
    check("R4 next sample uses trk gain", 17);

    do_restart();
    cyc(1'b1, 64, 1'b0, 1'b0);
    check("R1 restart returns acq gain", 16);

    chan_bw = 16'd256; limit_sel = 2'd1;
    do_restart();
    cyc(1'b1, 1000, 1'b0, 1'b0);
    check("R5 clamp +BW/8", 32);
    cyc(1'b1, -1000, 1'b0, 1'b0);
    cyc(1'b1, -1000, 1'b0, 1'b0);
    check("R5 clamp -BW/8", -32);
    limit_sel = 2'd2;
    cyc(1'b1, 1000, 1'b0, 1'b0);
    cyc(1'b1, 1000, 1'b0, 1'b0);
    check("R5 clamp +BW/4", 64);
    limit_sel = 2'd3;
    cyc(1'b1, 1000, 1'b0, 1'b0);
    cyc(1'b1, 1000, 1'b0, 1'b0);
    cyc(1'b1, 1000, 1'b0, 1'b0);
    check("R5 clamp +BW/2", 128);

    limit_sel = 2'd0;
    cyc(1'b1, 1000, 1'b0, 1'b0);
    check("R6 off forces zero", 0);
    cyc(1'b1, 1000, 1'b0, 1'b0);
    check("R6 off ignores samples", 0);

    limit_sel = 2'd3; chan_bw = 16'd4000;
    cyc(1'b1, 64, 1'b0, 1'b0);
    check("R6 re-enable update", 16);
    ook_mode = 1'b1;
    cyc(1'b1, 64, 1'b0, 1'b0);
    check("R7 ook zero", 0);
    cyc(1'b1, 64, 1'b0, 1'b0);
    check("R7 ook ignores samples", 0);
    ook_mode = 1'b0;

    cs_gate_en = 1'b1;
    do_restart();
    cyc(1'b1, 64, 1'b0, 1'b0);
    cyc(1'b1, 64, 1'b0, 1'b0);
    check("R8 frozen before carrier", 0);
    cyc(1'b0, 0, 1'b0, 1'b1);
    cyc(1'b1, 64, 1'b0, 1'b0);
    check("R8 remembered carrier", 16);
    do_restart();
    cyc(1'b1, 64, 1'b0, 1'b0);
    check("R8 restart re-arms gate", 0);
    cyc(1'b1, 64, 1'b0, 1'b1);
    check("R8 same-cycle carrier", 16);
    cs_gate_en = 1'b0;

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset mid-run", 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule